// File: doc/BRIEF.md
# Modem Receive USART

This block is the receive-side character engine for a modem data path. It takes the demodulated serial line together with a once-per-bit strobe and a 16x oversampling enable. In synchronous framing it collects every bit into a shift buffer and hands whole bytes, or whole byte pairs, to a host data register. In start-stop framing it hunts for a start bit, confirms it at the bit centre, gathers 5 to 8 data bits least-significant bit first, then samples an optional parity bit and the stop bit.

Received characters are packed into a 16-bit host word, either one at a time or two at a time. In paired packing, a lone character is flushed after a programmable number of idle bit strobes, and a flag tells the host whether one or two characters are valid. Per-character received parity, a framing-error flag and a sticky overrun flag go out with the word. A character with a missing stop bit is still delivered, and the receiver then waits for the line to go high before it hunts for the next start bit.

Top module: `modem_rx_usart`

## Requirements
- R1: With cfg_async_i=0 and cfg_pair_i=0, each bit_en_i strobe shifts rx_i into the buffer. After 8 strobes the byte is delivered to data_o[7:0], with the first bit received at bit 0, data_o[15:8]=0 and pair_o=0.
- R2: With cfg_async_i=0 and cfg_pair_i=1, a word is delivered after 16 strobes, with the first bit received at data_o bit 0 and pair_o=1.
- R3: With cfg_async_i=1, a low line is confirmed as a start bit 8 oversample ticks after it is first seen. If the line is high at that point, the start is dropped as a glitch and nothing is delivered.
- R4: cfg_len_i selects 5+cfg_len_i data bits (0..3 gives 5..8 bits), received least-significant bit first. Unused upper bits of each character byte read 0.
- R5: With cfg_par_en_i=1, the bit after the data bits is the parity bit. Its received value appears on par_o[0] for the first character and on par_o[1] for the second. It is never placed in the data. With cfg_par_en_i=0, par_o reads 0.
- R6: A 0 sampled in the stop position still delivers the character, with frm_err_o=1. A good stop bit gives frm_err_o=0.
- R7: After a framing error, the receiver ignores the line while it stays low and takes the next 1-to-0 transition as the next start bit.
- R8: In start-stop framing with cfg_pair_i=1, the first character goes to data_o[7:0] and the second to data_o[15:8]. Both are delivered together with pair_o=1.
- R9: With cfg_pair_i=1, a lone pending character is delivered once cfg_timeout_i bit_en_i strobes have passed with the receiver idle. It is delivered in data_o[7:0] with pair_o=0 and data_o[15:8]=0.
- R10: ready_o rises one cycle after a word is delivered and falls after rd_ack_i, unless a new word is delivered in the same cycle.
- R11: A delivery while ready_o=1 and rd_ack_i=0 overwrites the word and sets ovr_o. ovr_o stays set until ovr_clr_i is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_en_i | input | 1 | 16x oversampling tick |
| bit_en_i | input | 1 | Once-per-bit strobe (sync shifting, timeout) |
| rx_i | input | 1 | Received serial line |
| cfg_async_i | input | 1 | 1 = start-stop framing, 0 = synchronous |
| cfg_len_i | input | 2 | Data bits minus 5 (start-stop) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_pair_i | input | 1 | Two characters per host word |
| cfg_timeout_i | input | TMO_W | Idle bit strobes before a lone character is flushed |
| rd_ack_i | input | 1 | Host has read the word |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| data_o | output | 16 | Host data word |
| ready_o | output | 1 | Word waiting for the host |
| pair_o | output | 1 | 1 = 16 valid bits, 0 = only [7:0] valid |
| par_o | output | 2 | Received parity per character |
| frm_err_o | output | 1 | Missing stop bit in the delivered word |
| ovr_o | output | 1 | Sticky overrun |

## Verification
The bench uses the default OS_RATE of 16 and a TMO_W of 8, with os_en_i held high so that one bit lasts 16 clocks. In this setup the bit-centre sampling points and the glitch window fall on exact cycles. A timeout of 4 strobes lets the lone-character flush be seen both before and after it expires within a few hundred cycles. Synchronous bits are strobed every other clock, so byte and pair delivery complete quickly. A long low break after a missing stop bit exercises the realignment path.

// File: rtl/modem_rx_pkg.sv
package modem_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned WORD_W = 2 * CHAR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITH
  } rx_state_e;
endpackage

// File: rtl/rx_sync_shifter.sv
module rx_sync_shifter
  import modem_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_en_i,
  input  logic              rx_i,
  input  logic              pair_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_next;
  logic [CNT_W-1:0]  cnt_q, last;

  assign sh_next = {rx_i, sh_q[WORD_W-1:1]};
  assign last    = pair_i ? CNT_W'(WORD_W - 1) : CNT_W'(CHAR_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (bit_en_i) begin
        sh_q <= sh_next;
        if (cnt_q == last) begin
          cnt_q  <= '0;
          vld_o  <= 1'b1;
          word_o <= pair_i ? sh_next : {{CHAR_W{1'b0}}, sh_next[WORD_W-1:CHAR_W]};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_sync_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !$past(pair_i)) |-> word_o[WORD_W-1:CHAR_W] == '0);
endmodule

// File: rtl/rx_async_framer.sv
module rx_async_framer
  import modem_rx_pkg::*;
#(
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              os_en_i,
  input  logic              rx_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  output logic              vld_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              idle_o
);
  localparam int unsigned OS_W = $clog2(OS_RATE);
  localparam logic [OS_W-1:0] HALF = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0] FULL = OS_W'(OS_RATE - 1);

  rx_state_e         st_q;
  logic [OS_W-1:0]   cnt_q;
  logic [2:0]        nbit_q, last_bit;
  logic [CHAR_W-1:0] sh_q;
  logic              mid;

  assign last_bit = {1'b0, len_i} + 3'd4;
  assign mid      = os_en_i && (cnt_q == FULL);
  assign idle_o   = (st_q == ST_IDLE) || (st_q == ST_WAITH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      vld_o  <= 1'b0;
      char_o <= '0;
      par_o  <= 1'b0;
      frm_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else if (os_en_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (st_q)
          ST_IDLE: if (!rx_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
          ST_START: if (cnt_q == HALF) begin
            cnt_q  <= '0;
            nbit_q <= '0;
            par_o  <= 1'b0;
            st_q   <= rx_i ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (mid) begin
            sh_q <= {rx_i, sh_q[CHAR_W-1:1]};
            if (nbit_q == last_bit) st_q <= par_en_i ? ST_PAR : ST_STOP;
            nbit_q <= nbit_q + 1'b1;
          end
          ST_PAR: if (mid) begin
            par_o <= rx_i;
            st_q  <= ST_STOP;
          end
          ST_STOP: if (mid) begin
            vld_o  <= 1'b1;
            char_o <= sh_q >> (2'd3 - len_i);
            frm_o  <= !rx_i;
            st_q   <= rx_i ? ST_IDLE : ST_WAITH;
          end
          ST_WAITH: if (rx_i) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_glitch_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && os_en_i && st_q == ST_START && cnt_q == HALF && rx_i) |=> st_q == ST_IDLE && !vld_o);
  p_frm_resync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_WAITH && !rx_i) |=> st_q != ST_START);
  p_frm_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && frm_o) |-> st_q == ST_WAITH || !en_i || $past(!rx_i));
endmodule

// File: rtl/rx_char_packer.sv
module rx_char_packer
  import modem_rx_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              async_i,
  input  logic              pair_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              bit_en_i,
  input  logic              idle_i,
  input  logic              a_vld_i,
  input  logic [CHAR_W-1:0] a_char_i,
  input  logic              a_par_i,
  input  logic              a_frm_i,
  input  logic              s_vld_i,
  input  logic [WORD_W-1:0] s_word_i,
  input  logic              rd_ack_i,
  input  logic              ovr_clr_i,
  output logic [WORD_W-1:0] data_o,
  output logic              ready_o,
  output logic              pair_o,
  output logic [1:0]        par_o,
  output logic              frm_err_o,
  output logic              ovr_o
);
  logic              have_q, p0_q, f0_q;
  logic [CHAR_W-1:0] lo_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              flush, dlv;
  logic [WORD_W-1:0] d_word;
  logic              d_pair, d_frm;
  logic [1:0]        d_par;

  assign flush = async_i && have_q && idle_i && bit_en_i && !a_vld_i
                 && ((tmo_q + 1'b1) >= timeout_i);

  always_comb begin
    dlv    = 1'b0;
    d_word = '0;
    d_pair = 1'b0;
    d_par  = '0;
    d_frm  = 1'b0;
    if (!async_i) begin
      dlv    = s_vld_i;
      d_word = s_word_i;
      d_pair = pair_i;
    end else if (a_vld_i && (!pair_i || !have_q)) begin
      dlv    = !pair_i;
      d_word = {{CHAR_W{1'b0}}, a_char_i};
      d_par  = {1'b0, a_par_i};
      d_frm  = a_frm_i;
    end else if (a_vld_i) begin
      dlv    = 1'b1;
      d_word = {a_char_i, lo_q};
      d_pair = 1'b1;
      d_par  = {a_par_i, p0_q};
      d_frm  = a_frm_i | f0_q;
    end else if (flush) begin
      dlv    = 1'b1;
      d_word = {{CHAR_W{1'b0}}, lo_q};
      d_par  = {1'b0, p0_q};
      d_frm  = f0_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      lo_q   <= '0;
      p0_q   <= 1'b0;
      f0_q   <= 1'b0;
      tmo_q  <= '0;
    end else begin
      if (!async_i || !pair_i) begin
        have_q <= 1'b0;
      end else if (a_vld_i) begin
        have_q <= !have_q;
        lo_q   <= a_char_i;
        p0_q   <= a_par_i;
        f0_q   <= a_frm_i;
        tmo_q  <= '0;
      end else if (flush) begin
        have_q <= 1'b0;
      end else if (have_q && idle_i && bit_en_i) begin
        tmo_q <= tmo_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      pair_o    <= 1'b0;
      par_o     <= '0;
      frm_err_o <= 1'b0;
      ovr_o     <= 1'b0;
    end else begin
      if (dlv) begin
        data_o    <= d_word;
        pair_o    <= d_pair;
        par_o     <= d_par;
        frm_err_o <= d_frm;
        ready_o   <= 1'b1;
      end else if (rd_ack_i) begin
        ready_o <= 1'b0;
      end
      if (dlv && ready_o && !rd_ack_i) ovr_o <= 1'b1;
      else if (ovr_clr_i)              ovr_o <= 1'b0;
    end
  end

  p_flush_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> ready_o && !pair_o && data_o[WORD_W-1:CHAR_W] == '0);
  p_ack_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_i && !dlv) |=> !ready_o);
  p_ovr_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv && ready_o && !rd_ack_i) |=> ovr_o);
  p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: rtl/modem_rx_usart.sv
module modem_rx_usart
  import modem_rx_pkg::*;
#(
  parameter int unsigned OS_RATE = 16,
  parameter int unsigned TMO_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             os_en_i,
  input  logic             bit_en_i,
  input  logic             rx_i,
  input  logic             cfg_async_i,
  input  logic [1:0]       cfg_len_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_pair_i,
  input  logic [TMO_W-1:0] cfg_timeout_i,
  input  logic             rd_ack_i,
  input  logic             ovr_clr_i,
  output logic [15:0]      data_o,
  output logic             ready_o,
  output logic             pair_o,
  output logic [1:0]       par_o,
  output logic             frm_err_o,
  output logic             ovr_o
);
  logic              a_vld, a_par, a_frm, a_idle, s_vld;
  logic [CHAR_W-1:0] a_char;
  logic [WORD_W-1:0] s_word;

  rx_sync_shifter u_sync (
    .clk_i, .rst_ni,
    .en_i    (!cfg_async_i),
    .bit_en_i,
    .rx_i,
    .pair_i  (cfg_pair_i),
    .vld_o   (s_vld),
    .word_o  (s_word)
  );

  rx_async_framer #(.OS_RATE(OS_RATE)) u_async (
    .clk_i, .rst_ni,
    .en_i     (cfg_async_i),
    .os_en_i,
    .rx_i,
    .len_i    (cfg_len_i),
    .par_en_i (cfg_par_en_i),
    .vld_o    (a_vld),
    .char_o   (a_char),
    .par_o    (a_par),
    .frm_o    (a_frm),
    .idle_o   (a_idle)
  );

  rx_char_packer #(.TMO_W(TMO_W)) u_pack (
    .clk_i, .rst_ni,
    .async_i   (cfg_async_i),
    .pair_i    (cfg_pair_i),
    .timeout_i (cfg_timeout_i),
    .bit_en_i,
    .idle_i    (a_idle),
    .a_vld_i   (a_vld),
    .a_char_i  (a_char),
    .a_par_i   (a_par),
    .a_frm_i   (a_frm),
    .s_vld_i   (s_vld),
    .s_word_i  (s_word),
    .rd_ack_i,
    .ovr_clr_i,
    .data_o, .ready_o, .pair_o, .par_o, .frm_err_o, .ovr_o
  );

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !pair_o) |-> data_o[15:8] == 8'h00);
  p_no_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && !$past(cfg_par_en_i) && $past(cfg_async_i)) |-> par_o == 2'b00);
endmodule

// File: tb/modem_rx_usart_tb_top.sv
module modem_rx_usart_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_en = 1'b1, bit_en = 1'b0, rx = 1'b1;
  logic        cfg_async = 1'b1, cfg_par_en = 1'b0, cfg_pair = 1'b0;
  logic [1:0]  cfg_len = 2'd3;
  logic [7:0]  cfg_timeout = 8'd4;
  logic        rd_ack = 1'b0, ovr_clr = 1'b0;
  logic [15:0] data;
  logic        ready, pair, frm_err, ovr;
  logic [1:0]  par;
  logic        auto_bit = 1'b1;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  modem_rx_usart dut_i (
    .clk_i(clk), .rst_ni(rst_n), .os_en_i(os_en), .bit_en_i(bit_en), .rx_i(rx),
    .cfg_async_i(cfg_async), .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_par_en),
    .cfg_pair_i(cfg_pair), .cfg_timeout_i(cfg_timeout), .rd_ack_i(rd_ack),
    .ovr_clr_i(ovr_clr), .data_o(data), .ready_o(ready), .pair_o(pair),
    .par_o(par), .frm_err_o(frm_err), .ovr_o(ovr)
  );

  initial begin : bit_gen
    int ctr = 0;
    forever begin
      @(negedge clk);
      if (auto_bit) begin
        bit_en = (ctr == 15);
        ctr = (ctr + 1) % 16;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input int nb, input logic pe,
                           input logic pb, input logic stop);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(c[i]);
    if (pe) hold_bit(pb);
    hold_bit(stop);
    rx = 1'b1;
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  task automatic sync_bits(input logic [15:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      rx = w[i]; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      @(negedge clk);
    end
  endtask

  // {len, par_en, par_bit, stop, char, exp_data, exp_frm, exp_par}
  localparam logic [22:0] VEC [6] = '{
    {2'd3, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h15, 8'h15, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h2B, 8'h2B, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1, 8'h7F, 8'h7F, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h81, 8'h81, 1'b1, 1'b1},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R10 reset ready", ready, 0);
    chk("R11 reset ovr", ovr, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // table walk: single-character start-stop (R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      cfg_len = VEC[v][22:21];
      cfg_par_en = VEC[v][20];
      send_char(VEC[v][17:10], 5 + int'(VEC[v][22:21]), VEC[v][20], VEC[v][19], VEC[v][18]);
      if (!VEC[v][18]) hold_bit(1'b1);
      chk("R10 ready after char", ready, 1);
      chk("R4 char data", data, {8'h00, VEC[v][9:2]});
      chk("R6 frame flag", frm_err, VEC[v][1]);
      chk("R5 parity", par, {1'b0, VEC[v][0]});
      ack();
      chk("R10 ack clears", ready, 0);
      hold_bit(1'b1);
    end

    cfg_len = 2'd3; cfg_par_en = 1'b0;
    // R3 glitch: low for 4 clocks only
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 glitch ignored", ready, 0);
    send_char(8'hC3, 8, 0, 0, 1);
    chk("R3 char after glitch", data, 16'h00C3);
    ack();

    // R7 resync: missing stop, line held low as a break
    send_char(8'h3C, 8, 0, 0, 0);
    rx = 1'b0;
    chk("R6 frm char kept", data, 16'h003C);
    chk("R6 frm flag", frm_err, 1);
    ack();
    repeat (64) @(negedge clk);
    chk("R7 no start during break", ready, 0);
    hold_bit(1'b1);
    send_char(8'h96, 8, 0, 0, 1);
    chk("R7 realigned char", data, 16'h0096);
    chk("R7 frm cleared", frm_err, 0);
    ack();

    // R8 pair packing with parity
    cfg_pair = 1'b1; cfg_par_en = 1'b1;
    send_char(8'h11, 8, 1, 1, 1);
    chk("R8 no word after first", ready, 0);
    send_char(8'hE2, 8, 1, 0, 1);
    chk("R8 pair word", data, 16'hE211);
    chk("R8 pair flag", pair, 1);
    chk("R5 pair parity", par, 2'b01);
    ack();

    // R9 timeout flush of a lone character
    send_char(8'h47, 8, 1, 0, 1);
    chk("R9 pending before timeout", ready, 0);
    repeat (16 * 6) @(negedge clk);
    chk("R9 flushed", ready, 1);
    chk("R9 lone data", data, 16'h0047);
    chk("R9 pair cleared", pair, 0);
    ack();

    // R11 overrun
    cfg_pair = 1'b0; cfg_par_en = 1'b0;
    send_char(8'h01, 8, 0, 0, 1);
    send_char(8'h02, 8, 0, 0, 1);
    chk("R11 overwrite", data, 16'h0002);
    chk("R11 ovr set", ovr, 1);
    ack();
    chk("R11 ovr sticky", ovr, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk("R11 ovr cleared", ovr, 0);

    // synchronous framing
    cfg_async = 1'b0; auto_bit = 1'b0; bit_en = 1'b0;
    @(negedge clk);
    sync_bits(16'h00A5, 8);
    chk("R1 sync byte", data, 16'h00A5);
    chk("R1 sync pair flag", pair, 0);
    ack();
    cfg_pair = 1'b1;
    sync_bits(16'h3C5A, 15);
    chk("R2 no word at 15 bits", ready, 0);
    sync_bits(16'h0001, 1);
    chk("R2 sync word", data, 16'hBC5A);
    chk("R2 sync pair flag", pair, 1);
    ack();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule